// File: doc/BRIEF.md
# Programmable-Order Output Readout Buffer

This block lets a host or a DMA engine collect the results of four synchronized receive channels through one 16-bit read address. Each channel supplies a 24-bit I sample, a 24-bit Q sample, a 24-bit magnitude, a 16-bit phase and a 16-bit AGC value. A host-written order table of up to 32 entries names which channel and which 16-bit word type to fetch, and in what sequence.

When the output-ready pulse arrives, the block formats the selected words and captures them into a buffer. It then rewinds its read pointer to the first word. Each host read at the data address returns the word under the pointer and then advances the pointer, so a DMA engine can drain the whole set with back-to-back reads and no writes in between. A status flag at a second address tells a polling host that fresh data is waiting.

Top module: `rdo_readout_buf`

## Requirements
- R1: After reset, every table entry is invalid, status bit 0 at address 3 reads 0, and a read at address 2 returns 0x0000.
- R2: Word type codes are: 0 = I[23:8], 1 = {I[7:0],8'h00}, 2 = Q[23:8], 3 = {Q[7:0],8'h00}, 4 = Mag[23:8], 5 = {Mag[7:0],8'h00}, 6 = Phase[15:0], 7 = AGC[15:0].
- R3: A table entry is 6 bits: bit 5 valid, bits 4:3 channel, bits 2:0 word type. Buffer word k comes from table entry k. Channel c occupies bits [c*24 +: 24] of the 24-bit inputs and bits [c*16 +: 16] of the 16-bit inputs.
- R4: A load captures entries from 0 up to, but not including, the first invalid entry. Valid entries after that entry are ignored.
- R5: A read at address 2 with rd_i high returns the word under the pointer on rd_data_o in the same cycle. The pointer then moves on by one at the clock edge.
- R6: Once the pointer reaches the loaded count, reads at address 2 return 0x0000, and the pointer neither wraps nor moves.
- R7: A load_i pulse rewinds the pointer to word 0 and refills the buffer from the current inputs. If a read occurs in the same cycle as the pulse, the load takes precedence.
- R8: Status bit 0 at address 3 is set by a load and cleared by the first read at address 2 that follows it. Reads at address 3 or at other addresses do not move the pointer, and addresses other than 2 and 3 read 0x0000.
- R9: The upper words are truncations of the 24-bit values and are not rounded.
- R10: Table writes take effect only at the next load. Data already in the buffer does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Output-ready pulse that triggers a buffer load |
| i_data_i | input | 96 | Per-channel I samples, 24 bits each |
| q_data_i | input | 96 | Per-channel Q samples, 24 bits each |
| mag_data_i | input | 96 | Per-channel magnitude, 24 bits each |
| phase_i | input | 64 | Per-channel phase, 16 bits each |
| agc_i | input | 64 | Per-channel AGC, 16 bits each |
| tbl_we_i | input | 1 | Order table write strobe |
| tbl_addr_i | input | 5 | Order table entry index |
| tbl_data_i | input | 6 | Entry: {valid, channel[1:0], type[2:0]} |
| rd_i | input | 1 | Host read strobe |
| rd_addr_i | input | 3 | Host read address (2 = data, 3 = status) |
| rd_data_o | output | 16 | Host read data |

## Verification
The case that is hardest to reach from the ports is a table with valid entries placed after a gap. Stopping at the first invalid entry differs from counting all valid entries only in that arrangement. The bench therefore writes a gap at index 3 and a valid entry at index 4, and confirms that reads past word 2 return zero. A second hard case is a read that lands in the same cycle as a load pulse. The bench issues both in one cycle, then checks that the next read returns word 0 of the new data and that the status flag is set.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
  localparam int CH_W  = 2;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    W_I_HI, W_I_LO, W_Q_HI, W_Q_LO, W_M_HI, W_M_LO, W_PH, W_AGC
  } word_sel_e;

  typedef struct packed {
    logic             valid;
    logic [CH_W-1:0]  ch;
    word_sel_e        sel;
  } entry_t;

  localparam int ENTRY_W = $bits(entry_t);
endpackage

// File: rtl/rdo_word_fmt.sv
module rdo_word_fmt #(
  parameter int NCH  = 4,
  parameter int WIDE = 24,
  parameter int NARW = 16
) (
  input  logic [NCH*WIDE-1:0] i_data_i,
  input  logic [NCH*WIDE-1:0] q_data_i,
  input  logic [NCH*WIDE-1:0] mag_data_i,
  input  logic [NCH*NARW-1:0] phase_i,
  input  logic [NCH*NARW-1:0] agc_i,
  output logic [15:0]         words_o [NCH*8]
);
  localparam int LO_W = WIDE - 16;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [WIDE-1:0] iv, qv, mv;
    assign iv = i_data_i[c*WIDE +: WIDE];
    assign qv = q_data_i[c*WIDE +: WIDE];
    assign mv = mag_data_i[c*WIDE +: WIDE];
    // plain truncation of the upper words, no rounding
    assign words_o[c*8+0] = iv[WIDE-1 -: 16];
    assign words_o[c*8+1] = {iv[LO_W-1:0], {(16-LO_W){1'b0}}};
    assign words_o[c*8+2] = qv[WIDE-1 -: 16];
    assign words_o[c*8+3] = {qv[LO_W-1:0], {(16-LO_W){1'b0}}};
    assign words_o[c*8+4] = mv[WIDE-1 -: 16];
    assign words_o[c*8+5] = {mv[LO_W-1:0], {(16-LO_W){1'b0}}};
    assign words_o[c*8+6] = phase_i[c*NARW +: 16];
    assign words_o[c*8+7] = agc_i[c*NARW +: 16];
  end
endmodule

// File: rtl/rdo_order_table.sv
module rdo_order_table
  import rdo_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [ENTRY_W-1:0] wdata_i,
  output entry_t             entries_o [DEPTH],
  output logic [CW-1:0]      count_o
);
  entry_t tbl_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) tbl_q[i] <= '0;
    end else if (we_i) begin
      tbl_q[addr_i] <= entry_t'(wdata_i);
    end
  end

  assign entries_o = tbl_q;

  // length of the valid run starting at entry 0
  always_comb begin
    count_o = CW'(DEPTH);
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!tbl_q[i].valid) count_o = CW'(i);
  end

  p_run_ends_invalid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o < CW'(DEPTH)) |-> !tbl_q[count_o[AW-1:0]].valid);
endmodule

// File: rtl/rdo_readout_buf.sv
module rdo_readout_buf
  import rdo_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int WIDE  = 24,
  parameter int NARW  = 16,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [NCH*WIDE-1:0] i_data_i,
  input  logic [NCH*WIDE-1:0] q_data_i,
  input  logic [NCH*WIDE-1:0] mag_data_i,
  input  logic [NCH*NARW-1:0] phase_i,
  input  logic [NCH*NARW-1:0] agc_i,
  input  logic                tbl_we_i,
  input  logic [AW-1:0]       tbl_addr_i,
  input  logic [ENTRY_W-1:0]  tbl_data_i,
  input  logic                rd_i,
  input  logic [2:0]          rd_addr_i,
  output logic [15:0]         rd_data_o
);
  localparam logic [2:0] A_DATA = 3'd2;
  localparam logic [2:0] A_STAT = 3'd3;

  logic [15:0] words [NCH*8];
  entry_t      entries [DEPTH];
  logic [CW-1:0] run_len;

  rdo_word_fmt #(.NCH(NCH), .WIDE(WIDE), .NARW(NARW)) u_fmt (
    .i_data_i(i_data_i), .q_data_i(q_data_i), .mag_data_i(mag_data_i),
    .phase_i(phase_i), .agc_i(agc_i), .words_o(words)
  );

  rdo_order_table #(.DEPTH(DEPTH)) u_tbl (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(tbl_we_i), .addr_i(tbl_addr_i),
    .wdata_i(tbl_data_i), .entries_o(entries), .count_o(run_len)
  );

  logic [15:0]   buf_q [DEPTH];
  logic [CW-1:0] depth_q, ptr_q;
  logic          new_q;
  logic          data_rd;

  assign data_rd = rd_i && (rd_addr_i == A_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) buf_q[i] <= '0;
      depth_q <= '0;
      ptr_q   <= '0;
      new_q   <= 1'b0;
    end else if (load_i) begin
      for (int i = 0; i < DEPTH; i++)
        buf_q[i] <= words[{entries[i].ch, entries[i].sel}];
      depth_q <= run_len;
      ptr_q   <= '0;
      new_q   <= 1'b1;
    end else if (data_rd) begin
      new_q <= 1'b0;
      if (ptr_q < depth_q) ptr_q <= ptr_q + 1'b1;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == A_DATA) begin
      if (ptr_q < depth_q) rd_data_o = buf_q[ptr_q[AW-1:0]];
    end else if (rd_addr_i == A_STAT) begin
      rd_data_o = {15'd0, new_q};
    end
  end

  p_load_rewinds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (ptr_q == '0) && new_q);
  p_ptr_steps_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd && !load_i && (ptr_q < depth_q)) |=> ptr_q == $past(ptr_q) + 1'b1);
  p_no_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= depth_q);
  p_end_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_addr_i == A_DATA) && (ptr_q == depth_q)) |-> rd_data_o == 16'h0000);
  p_flag_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd && !load_i) |=> !new_q);
  p_stat_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!data_rd && !load_i) |=> $stable(ptr_q));
endmodule

// File: tb/rdo_readout_buf_tb.sv
module rdo_readout_buf_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        load = 0;
  logic [95:0] iv = '0, qv = '0, mv = '0;
  logic [63:0] pv = '0, av = '0;
  logic        twe = 0;
  logic [4:0]  taddr = '0;
  logic [5:0]  tdata = '0;
  logic        rd = 0;
  logic [2:0]  raddr = '0;
  logic [15:0] rdata;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rdo_readout_buf dut_i (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load),
    .i_data_i(iv), .q_data_i(qv), .mag_data_i(mv), .phase_i(pv), .agc_i(av),
    .tbl_we_i(twe), .tbl_addr_i(taddr), .tbl_data_i(tdata),
    .rd_i(rd), .rd_addr_i(raddr), .rd_data_o(rdata)
  );

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] model(int ch, int sel);
    logic [23:0] i24 = iv[ch*24 +: 24];
    logic [23:0] q24 = qv[ch*24 +: 24];
    logic [23:0] m24 = mv[ch*24 +: 24];
    case (sel)
      0: return i24[23:8];
      1: return {i24[7:0], 8'h00};
      2: return q24[23:8];
      3: return {q24[7:0], 8'h00};
      4: return m24[23:8];
      5: return {m24[7:0], 8'h00};
      6: return pv[ch*16 +: 16];
      default: return av[ch*16 +: 16];
    endcase
  endfunction

  task automatic twr(int idx, bit v, int ch, int sel);
    @(negedge clk);
    twe = 1; taddr = 5'(idx); tdata = {v, 2'(ch), 3'(sel)};
    @(negedge clk);
    twe = 0;
  endtask

  task automatic pulse_load();
    @(negedge clk); load = 1;
    @(negedge clk); load = 0;
  endtask

  task automatic host_rd(logic [2:0] a, output logic [15:0] d);
    @(negedge clk); raddr = a; rd = 1; #1 d = rdata;
    @(negedge clk); rd = 0;
  endtask

  task automatic peek(logic [2:0] a, output logic [15:0] d);
    @(negedge clk); raddr = a; rd = 0; #1 d = rdata;
  endtask

  task automatic set_data();
    for (int c = 0; c < 4; c++) begin
      iv[c*24 +: 24] = 24'h123400 + 24'(c * 24'h010111) + 24'hFF;
      qv[c*24 +: 24] = 24'hA5C300 + 24'(c * 24'h001021) + 24'h81;
      mv[c*24 +: 24] = 24'h7E0000 + 24'(c * 24'h030303) + 24'hC0;
      pv[c*16 +: 16] = 16'h4000 + 16'(c * 16'h0111);
      av[c*16 +: 16] = 16'h0F00 + 16'(c * 16'h1010);
    end
  endtask

  task automatic t_reset();
    logic [15:0] d;
    peek(3'd3, d); chk("R1 status", d, 16'h0);
    host_rd(3'd2, d); chk("R1 data", d, 16'h0);
  endtask

  task automatic t_formats();
    logic [15:0] d;
    set_data();
    for (int k = 0; k < 32; k++) twr(k, 1, k / 8, k % 8);
    pulse_load();
    for (int k = 0; k < 32; k++) begin
      host_rd(3'd2, d);
      chk($sformatf("R2 R3 R5 word %0d", k), d, model(k / 8, k % 8));
    end
    host_rd(3'd2, d); chk("R6 past full", d, 16'h0);
  endtask

  task automatic t_trunc();
    logic [15:0] d;
    iv[23:0] = 24'h12FFFF;
    twr(0, 1, 0, 0); twr(1, 0, 0, 0);
    pulse_load();
    host_rd(3'd2, d); chk("R9 no rounding", d, 16'h12FF);
  endtask

  task automatic t_stop();
    logic [15:0] d;
    set_data();
    twr(0, 1, 3, 7); twr(1, 1, 1, 5); twr(2, 1, 2, 2);
    twr(3, 0, 0, 0); twr(4, 1, 0, 6);
    pulse_load();
    host_rd(3'd2, d); chk("R3 order 0", d, model(3, 7));
    host_rd(3'd2, d); chk("R3 order 1", d, model(1, 5));
    host_rd(3'd2, d); chk("R3 order 2", d, model(2, 2));
    host_rd(3'd2, d); chk("R4 stop at gap", d, 16'h0);
    host_rd(3'd2, d); chk("R6 no wrap", d, 16'h0);
  endtask

  task automatic t_status();
    logic [15:0] d;
    pulse_load();
    host_rd(3'd3, d); chk("R8 flag set", d, 16'h1);
    host_rd(3'd5, d); chk("R8 other addr zero", d, 16'h0);
    host_rd(3'd2, d); chk("R8 ptr unmoved", d, model(3, 7));
    peek(3'd3, d); chk("R8 flag cleared", d, 16'h0);
  endtask

  task automatic t_defer();
    logic [15:0] d;
    pulse_load();
    twr(0, 1, 0, 1);
    host_rd(3'd2, d); chk("R10 old buffer kept", d, model(3, 7));
    iv[23:0] = 24'hABCDEF;
    pulse_load();
    host_rd(3'd2, d); chk("R7 R10 fresh load", d, 16'hEF00);
  endtask

  task automatic t_collide();
    logic [15:0] d;
    host_rd(3'd2, d);
    @(negedge clk); load = 1; raddr = 3'd2; rd = 1;
    @(negedge clk); load = 0; rd = 0;
    peek(3'd3, d); chk("R7 flag after collide", d, 16'h1);
    host_rd(3'd2, d); chk("R7 load wins", d, model(0, 1));
  endtask

  initial begin
    #50000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_formats();
    t_trunc();
    t_stop();
    t_status();
    t_defer();
    t_collide();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule